// File: doc/BRIEF.md
# Add/Subtract Unit with Carry Control

This block is a two's-complement adder whose behaviour is set by two independent control strobes rather than by an opcode. One strobe, invert-and-force, complements operand B and contributes a forced carry of one. The other strobe, use-flag, routes the stored carry flag into the carry input. Plain addition, subtraction and add-with-carry are each one combination of these strobes. The fourth combination is produced by no valid operation code, but it still gives a defined arithmetic result.

A small decoder turns a 2-bit operation code into the strobe pair. A select input can bypass the decoder and apply the strobes directly, which makes every combination reachable. The datapath is purely combinational. Result and carry-out follow the inputs with no clock and no internal state.

Top module: `addsub_unit`

## Requirements
- R1: With neither strobe asserted, `{carryOut, result}` equals A + B with no carry-in, and `carryFlag` has no effect.
- R2: With both strobes asserted, `result` equals (A − B) mod 2^WIDTH and `carryOut` is 1 exactly when A ≥ B (no borrow). `carryFlag` has no effect.
- R3: With only the use-flag strobe asserted, `{carryOut, result}` equals A + B + carryFlag.
- R4: With only the invert-and-force strobe asserted, the unit computes A + ~B + 2. `result` is (A − B + 1) mod 2^WIDTH, and `carryOut` is 1 exactly when A − B + 1 ≥ 0.
- R5: When `ctlSel` is 0, the decoder drives the strobes from `opCode`: 2'b00 gives addition (R1), 2'b01 gives subtraction (R2), and 2'b10 gives add-with-carry (R3). No code produces the invert-only combination.
- R6: `opCode` 2'b11 asserts neither strobe and behaves exactly as addition.
- R7: When `ctlSel` is 1, the strobes come from `directCtl`: bit 1 is invert-and-force and bit 0 is use-flag. In this mode `opCode` has no effect. When `ctlSel` is 0, `directCtl` has no effect.
- R8: `carryOut` is 1 whenever the full-precision total of A, the conditioned B and the effective carry-in is at least 2^WIDTH. This holds in every mode, including totals up to 2^(WIDTH+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand, complemented when invert-and-force is active |
| carryFlag | input | 1 | Stored carry flag from a previous operation |
| opCode | input | 2 | Operation code for the decoder (00 add, 01 sub, 10 add-with-carry, 11 add) |
| ctlSel | input | 1 | 0: strobes come from the decoder; 1: strobes come from directCtl |
| directCtl | input | 2 | Direct strobes: bit 1 invert-and-force, bit 0 use-flag |
| result | output | WIDTH | Low WIDTH bits of the sum |
| carryOut | output | 1 | Carry above the MSB of the sum |

## Verification
The unit holds no state. Any wrong internal value therefore appears at the ports in the same cycle the inputs are applied. A wrong strobe decode or carry-in selection shows up as a result that is off by one or two, or as a complemented operand, and that error moves the carry-out as well. The bench applies each operand pattern and compares both outputs a nanosecond later against a full-precision reference. It places operands at zero, all-ones, equal values and adjacent values, where an off-by-one carry-in changes the carry-out.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  // Operation codes seen by the decoder
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_ADC = 2'b10,
    OP_RSV = 2'b11
  } addOp_e;

  // Strobe pair passed from control to datapath
  typedef struct packed {
    logic invForce;  // complement B, force a carry of one
    logic useFlag;   // carry-in taken from the stored flag
  } addStrobe_t;

endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
  import addsub_pkg::*;
(
  input  logic [1:0] opCode,
  output addStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    unique case (addOp_e'(opCode))
      OP_ADD: strobe = '{invForce: 1'b0, useFlag: 1'b0};
      OP_SUB: strobe = '{invForce: 1'b1, useFlag: 1'b1};
      OP_ADC: strobe = '{invForce: 1'b0, useFlag: 1'b1};
      default: strobe = '0;  // reserved code acts as plain add
    endcase
  end

  // R5: decoder never emits the invert-only combination
  always_comb begin
    p_no_lone_invert_r5: assert (!(strobe.invForce && !strobe.useFlag))
      else $error("decoder produced invert-only strobes");
  end

  // R6: reserved code leaves both strobes low
  always_comb begin
    if (opCode == 2'b11) begin
      p_rsv_quiet_r6: assert (strobe == '0)
        else $error("reserved code drove a strobe");
    end
  end

endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryFlag,
  input  addStrobe_t       strobe,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  localparam int TOTW = WIDTH + 2;

  logic [WIDTH-1:0] condB;
  logic [1:0]       cinVal;
  logic [TOTW-1:0]  total;

  // Per-bit conditional inversion of B
  for (genvar i = 0; i < WIDTH; i++) begin : g_cond
    assign condB[i] = opB[i] ^ strobe.invForce;
  end

  // Effective carry-in: 0, flag, 1 or 2
  always_comb begin
    unique case ({strobe.invForce, strobe.useFlag})
      2'b00:   cinVal = 2'd0;
      2'b01:   cinVal = {1'b0, carryFlag};
      2'b11:   cinVal = 2'd1;
      default: cinVal = 2'd2;
    endcase
  end

  assign total    = {2'b00, opA} + {2'b00, condB} + {{WIDTH{1'b0}}, cinVal};
  assign result   = total[WIDTH-1:0];
  assign carryOut = |total[TOTW-1:WIDTH];

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryFlag,
  input  logic [1:0]       opCode,
  input  logic             ctlSel,
  input  logic [1:0]       directCtl,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  localparam int TOTW = WIDTH + 2;

  addStrobe_t decStrobe;
  addStrobe_t activeStrobe;

  addsub_decode u_decode (
    .opCode (opCode),
    .strobe (decStrobe)
  );

  assign activeStrobe = ctlSel ? addStrobe_t'(directCtl) : decStrobe;

  addsub_datapath #(.WIDTH(WIDTH)) u_datapath (
    .opA       (opA),
    .opB       (opB),
    .carryFlag (carryFlag),
    .strobe    (activeStrobe),
    .result    (result),
    .carryOut  (carryOut)
  );

  // Port-level arithmetic checks against full-precision sums
  logic [TOTW-1:0] outTotal;
  logic [TOTW-1:0] sumPlain;
  logic [TOTW-1:0] sumFlag;
  logic [TOTW-1:0] diffWide;

  assign outTotal = {1'b0, carryOut, result};
  assign sumPlain = {2'b00, opA} + {2'b00, opB};
  assign sumFlag  = sumPlain + {{(TOTW-1){1'b0}}, carryFlag};
  assign diffWide = {2'b00, opA} - {2'b00, opB};

  always_comb begin
    unique case ({activeStrobe.invForce, activeStrobe.useFlag})
      2'b00: p_add_r1: assert (outTotal == sumPlain)
        else $error("add result mismatch");
      2'b01: p_adc_r3: assert (outTotal == sumFlag)
        else $error("add-with-carry mismatch");
      2'b11: p_sub_r2: assert ((result == diffWide[WIDTH-1:0]) && (carryOut == (opA >= opB)))
        else $error("subtract mismatch");
      default: p_lone_inv_r4: assert (result == WIDTH'(diffWide + 1'b1))
        else $error("invert-only mismatch");
    endcase
  end

endmodule

// File: tb/addsub_unit_bench.sv
`timescale 1ns/1ps
module addsub_unit_bench;

  localparam int W = 16;
  localparam longint MOD = 64'd1 << W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [W-1:0] opA = '0, opB = '0;
  logic         carryFlag = 1'b0;
  logic [1:0]   opCode = 2'b00;
  logic         ctlSel = 1'b0;
  logic [1:0]   directCtl = 2'b00;
  logic [W-1:0] result;
  logic         carryOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  addsub_unit #(.WIDTH(W)) u_addsub_unit (
    .opA(opA), .opB(opB), .carryFlag(carryFlag), .opCode(opCode),
    .ctlSel(ctlSel), .directCtl(directCtl), .result(result), .carryOut(carryOut)
  );

  // Reference: 0 add, 1 sub, 2 add-with-carry, 3 invert-only (A - B + 1)
  function automatic longint refTotal(int mode, longint a, longint b, longint f);
    case (mode)
      0: return a + b;
      1: return a - b + MOD;
      2: return a + b + f;
      default: return a - b + 1 + MOD;
    endcase
  endfunction

  function automatic int modeOfCode(logic [1:0] c);
    case (c)
      2'b01: return 1;
      2'b10: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int modeOfDirect(logic [1:0] d);
    case (d)
      2'b11: return 1;
      2'b01: return 2;
      2'b10: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic f,
                       input logic [1:0] code, input logic sel, input logic [1:0] dctl,
                       input string req);
    int mode;
    longint t;
    logic [W-1:0] expRes;
    logic expCo;
    @(posedge clk);
    opA = a; opB = b; carryFlag = f; opCode = code; ctlSel = sel; directCtl = dctl;
    #1;
    mode = sel ? modeOfDirect(dctl) : modeOfCode(code);
    t = refTotal(mode, longint'(a), longint'(b), longint'(f));
    expRes = W'(t % MOD);
    expCo = (t >= MOD);
    total++;
    if (result !== expRes || carryOut !== expCo) begin
      bad++;
      $display("FAIL %s: a=%h b=%h f=%0d code=%b sel=%0d dctl=%b got res=%h co=%0d exp res=%h co=%0d",
               req, a, b, f, code, sel, dctl, result, carryOut, expRes, expCo);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // quiescent state: all-zero inputs give zero outputs (R1)
    apply('0, '0, 1'b0, 2'b00, 1'b0, 2'b00, "R1 idle");

    // R1 add, flag ignored; carry from all-ones
    apply(16'hFFFF, 16'h0001, 1'b1, 2'b00, 1'b0, 2'b00, "R1 wrap");
    apply(16'h1234, 16'h4321, 1'b1, 2'b00, 1'b0, 2'b00, "R1 flag ignored");
    apply(16'hFFFF, 16'hFFFF, 1'b0, 2'b00, 1'b0, 2'b00, "R1 max");

    // R2 subtract, flag ignored, borrow edges
    apply(16'h0005, 16'h0005, 1'b0, 2'b01, 1'b0, 2'b00, "R2 equal");
    apply(16'h0004, 16'h0005, 1'b1, 2'b01, 1'b0, 2'b00, "R2 borrow");
    apply(16'h0000, 16'hFFFF, 1'b1, 2'b01, 1'b0, 2'b00, "R2 zero minus max");
    apply(16'h8000, 16'h0001, 1'b0, 2'b01, 1'b0, 2'b00, "R2 msb");

    // R3 add-with-carry
    apply(16'hFFFE, 16'h0001, 1'b1, 2'b10, 1'b0, 2'b00, "R3 carry ripple");
    apply(16'hFFFE, 16'h0001, 1'b0, 2'b10, 1'b0, 2'b00, "R3 no carry");
    apply(16'hFFFF, 16'hFFFF, 1'b1, 2'b10, 1'b0, 2'b00, "R3 max");

    // R6 reserved code behaves as add
    apply(16'hFFFF, 16'h0001, 1'b1, 2'b11, 1'b0, 2'b00, "R6 reserved");
    apply(16'h00FF, 16'h0F00, 1'b1, 2'b11, 1'b0, 2'b00, "R6 reserved flag");

    // R4 invert-only via direct strobes, R8 double carry-in edge
    apply(16'h0005, 16'h0003, 1'b0, 2'b00, 1'b1, 2'b10, "R4 basic");
    apply(16'h0004, 16'h0005, 1'b1, 2'b00, 1'b1, 2'b10, "R4 A one below B");
    apply(16'h0003, 16'h0005, 1'b0, 2'b00, 1'b1, 2'b10, "R4 negative");
    apply(16'hFFFF, 16'h0000, 1'b0, 2'b00, 1'b1, 2'b10, "R8 total 2^(W+1)");

    // R7 direct path ignores opCode; decoder path ignores directCtl
    apply(16'h1000, 16'h0001, 1'b1, 2'b01, 1'b1, 2'b00, "R7 direct add over sub code");
    apply(16'h1000, 16'h0001, 1'b1, 2'b00, 1'b1, 2'b11, "R7 direct sub");
    apply(16'h1000, 16'h0001, 1'b1, 2'b00, 1'b1, 2'b01, "R7 direct adc");
    apply(16'h1000, 16'h0001, 1'b1, 2'b00, 1'b0, 2'b10, "R7 directCtl ignored");

    // R5 decoder mapping under varied patterns, R8 across all modes
    for (int i = 0; i < 400; i++) begin
      apply(W'($urandom), W'($urandom), 1'($urandom), 2'($urandom), 1'b0, 2'($urandom), "R5 decoded random");
      apply(W'($urandom), W'($urandom), 1'($urandom), 2'($urandom), 1'b1, 2'($urandom), "R8 direct random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule